// File: doc/BRIEF.md
# CRT Black-Level Cut-off Sequencer

This block times the automatic black-level (cut-off) calibration of a three-gun picture tube. It watches the line and frame timing of the video path and produces the control strobes that an analog measurement front end needs. During each frame retrace it raises a leakage strobe, so that the standing leakage current of the tube can be captured and later subtracted. On the three lines after retrace it raises one measurement strobe per line, visiting the colour channels one at a time, and blanks the picture outputs while it does so.

At power-up the tube is cold and draws no beam current, so the cut-off loops would integrate garbage. The block therefore starts in a warm-up interlock. The loops are held off and a white-level insert is requested until the cathode-current sense reports beam. After that the insert is dropped and the loops run. Warm-up is left only once per reset.

The sequencer states are `S_IDLE` (between frames), `S_RETRACE` (leakage sampling), `S_WAIT` (retrace over, waiting for the first line start) and `S_MEAS` (one colour measurement line, with a channel index). The transitions are:
- `S_IDLE`→`S_RETRACE` when retrace is seen and warm-up is complete.
- `S_RETRACE`→`S_WAIT` when retrace ends.
- `S_WAIT`→`S_MEAS` on a line start, beginning at channel 0.
- `S_MEAS`→`S_MEAS` on a line start, advancing to the next channel.
- `S_MEAS`→`S_IDLE` on a line start after the last channel.
- Any of `S_WAIT` or `S_MEAS`→`S_RETRACE` when retrace is seen. This transition takes priority over a line start.

Top module: `crt_cutoff_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `white_insert` is 1 and `loop_en`, `leak_strobe`, `meas_strobe` and `blank_out` are all 0.
- R2: In the clock cycle after `beam_det` is sampled high on a rising edge, `loop_en` is 1 and `white_insert` is 0. Before that, `white_insert` is 1 and `loop_en` is 0.
- R3: Once warm-up has completed, `beam_det` returning low does not bring back `white_insert` or clear `loop_en` until the next reset.
- R4: While warm-up is in progress, `frame_retrace` and `line_pulse` are ignored: `leak_strobe` and `meas_strobe` stay 0.
- R5: After warm-up, `leak_strobe` is 1 from the cycle after `frame_retrace` is sampled high up to and including the cycle in which it is sampled low.
- R6: After retrace ends, each sampled `line_pulse` starts the next measurement line. The strobe is 3'b001 (bit 0, red), then 3'b010 (bit 1, green), then 3'b100 (bit 2, blue). The line start after the blue line returns `meas_strobe` to 0.
- R7: `line_pulse` has no effect during retrace. `blank_out` is 1 exactly in the cycles where a measurement strobe is active.
- R8: A `frame_retrace` sampled high during the wait or measurement lines aborts the sequence. In the next cycle `leak_strobe` is 1 and `meas_strobe` is 0.
- R9: `meas_strobe` has at most one bit set, and it is never active together with `leak_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_pulse | input | 1 | One-cycle pulse at the start of each line |
| frame_retrace | input | 1 | High for the duration of frame retrace |
| beam_det | input | 1 | Cathode current detected |
| leak_strobe | output | 1 | Sample leakage current |
| meas_strobe | output | NUM_CH | One-hot colour measurement strobe, bit 0 red |
| blank_out | output | 1 | Blank the picture outputs |
| loop_en | output | 1 | Cut-off loops enabled |
| white_insert | output | 1 | Request white-level insert |

## Verification
The assertions assume that `line_pulse` is a single-cycle event and that `frame_retrace` is a level lasting several cycles. They also assume that reset is held for at least one clock edge, so that every `$past` value is a reset value or a sampled one. The stimulus drives all inputs on the falling edge and keeps line pulses to one cycle, except in one deliberate run of back-to-back pulses. That run checks that the channel advances on every sampled pulse. Retrace is applied first during warm-up, then in full frames, and once in the middle of a measurement line.

// File: rtl/crt_cutoff_pkg.sv
package crt_cutoff_pkg;
    localparam int unsigned DEF_CHANNELS = 3;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RETRACE,
        S_WAIT,
        S_MEAS
    } seq_state_t;
endpackage

// File: rtl/crt_warmup_lock.sv
module crt_warmup_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic beam_det,
    output logic warm_done
);
    logic done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (beam_det) begin
            done_q <= 1'b1;
        end
    end

    assign warm_done = done_q;

    // R3: completion is sticky until reset
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done_q) |-> done_q);
endmodule

// File: rtl/crt_cutoff_fsm.sv
module crt_cutoff_fsm
    import crt_cutoff_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_CHANNELS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              line_pulse,
    input  logic              frame_retrace,
    output logic              leak_strobe,
    output logic [NUM_CH-1:0] meas_strobe,
    output logic              blank_out
);
    localparam int unsigned CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [CW-1:0] LAST_CH = CW'(NUM_CH - 1);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] ch_q, ch_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ch_q    <= '0;
        end else begin
            state_q <= state_d;
            ch_q    <= ch_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ch_d    = ch_q;
        unique case (state_q)
            S_IDLE: begin
                if (enable && frame_retrace) state_d = S_RETRACE;
            end
            S_RETRACE: begin
                if (!frame_retrace) state_d = S_WAIT;
            end
            S_WAIT: begin
                if (frame_retrace) begin
                    state_d = S_RETRACE;
                end else if (line_pulse) begin
                    state_d = S_MEAS;
                    ch_d    = '0;
                end
            end
            S_MEAS: begin
                if (frame_retrace) begin
                    state_d = S_RETRACE;
                end else if (line_pulse) begin
                    if (ch_q == LAST_CH) begin
                        state_d = S_IDLE;
                    end else begin
                        ch_d = ch_q + 1'b1;
                    end
                end
            end
        endcase
    end

    always_comb begin
        leak_strobe = (state_q == S_RETRACE);
        blank_out   = (state_q == S_MEAS);
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_strobe
        assign meas_strobe[g] = (state_q == S_MEAS) && (ch_q == CW'(g));
    end

    // R9: at most one colour strobe at a time
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(meas_strobe));
    // R9: leakage and colour strobes never overlap
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(leak_strobe && (|meas_strobe)));
    // R8: retrace during a measurement line aborts it
    a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
        ((|meas_strobe) && frame_retrace) |=> (leak_strobe && (meas_strobe == '0)));
    // R7: a line start during retrace does not open a measurement line
    a_r7_no_meas_in_retrace: assert property (@(posedge clk) disable iff (!rst_n)
        (leak_strobe && frame_retrace) |=> (meas_strobe == '0));
endmodule

// File: rtl/crt_cutoff_seq.sv
module crt_cutoff_seq
    import crt_cutoff_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_CHANNELS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_pulse,
    input  logic              frame_retrace,
    input  logic              beam_det,
    output logic              leak_strobe,
    output logic [NUM_CH-1:0] meas_strobe,
    output logic              blank_out,
    output logic              loop_en,
    output logic              white_insert
);
    logic warm_done;

    crt_warmup_lock u_warm (
        .clk      (clk),
        .rst_n    (rst_n),
        .beam_det (beam_det),
        .warm_done(warm_done)
    );

    crt_cutoff_fsm #(.NUM_CH(NUM_CH)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (warm_done),
        .line_pulse   (line_pulse),
        .frame_retrace(frame_retrace),
        .leak_strobe  (leak_strobe),
        .meas_strobe  (meas_strobe),
        .blank_out    (blank_out)
    );

    assign loop_en      = warm_done;
    assign white_insert = !warm_done;

    // R2: loops come on only after beam current was seen
    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loop_en) |-> $past(beam_det));
    // R4: no strobes while warm-up holds the loops off
    a_r4_quiet_warmup: assert property (@(posedge clk) disable iff (!rst_n)
        white_insert |-> (!leak_strobe && (meas_strobe == '0)));
    // R7: blanking follows the measurement lines
    a_r7_blank: assert property (@(posedge clk) disable iff (!rst_n)
        blank_out == (|meas_strobe));
    // R6: green follows red
    a_r6_order_g: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(meas_strobe[1]) |-> $past(meas_strobe[0]));
    // R6: blue follows green
    a_r6_order_b: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(meas_strobe[2]) |-> $past(meas_strobe[1]));
endmodule

// File: tb/crt_cutoff_seq_tb.sv
module crt_cutoff_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_pulse = 1'b0;
    logic       frame_retrace = 1'b0;
    logic       beam_det = 1'b0;
    logic       leak_strobe, blank_out, loop_en, white_insert;
    logic [2:0] meas_strobe;

    int checks = 0;
    int fails  = 0;

    // reference model: 0 idle, 1 retrace, 2 wait, 3 red, 4 green, 5 blue
    int m_st = 0;
    bit m_warm = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crt_cutoff_seq u_dut (
        .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse),
        .frame_retrace(frame_retrace), .beam_det(beam_det),
        .leak_strobe(leak_strobe), .meas_strobe(meas_strobe),
        .blank_out(blank_out), .loop_en(loop_en), .white_insert(white_insert)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st   <= 0;
            m_warm <= 1'b0;
        end else begin
            int n;
            n = m_st;
            case (m_st)
                0: if (m_warm && frame_retrace) n = 1;
                1: if (!frame_retrace) n = 2;
                default: begin
                    if (frame_retrace) n = 1;
                    else if (line_pulse) n = (m_st == 5) ? 0 : m_st + 1;
                end
            endcase
            m_st <= n;
            if (beam_det) m_warm <= 1'b1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_meas();
        return (m_st == 3) ? 1 : (m_st == 4) ? 2 : (m_st == 5) ? 4 : 0;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            check(leak_strobe == (m_st == 1), "R5 leak_strobe", leak_strobe, m_st == 1);
            check(meas_strobe == exp_meas(), "R6 meas_strobe", meas_strobe, exp_meas());
            check(blank_out == (m_st >= 3), "R7 blank_out", blank_out, m_st >= 3);
            check(loop_en == m_warm, "R2 loop_en", loop_en, m_warm);
            check(white_insert == !m_warm, "R2 white_insert", white_insert, !m_warm);
        end
    end

    task automatic pulse_line();
        @(negedge clk) line_pulse = 1'b1;
        @(negedge clk) line_pulse = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        idle(3);
        // R1: reset state while reset held
        check(white_insert == 1 && loop_en == 0 && leak_strobe == 0 && meas_strobe == 0 && blank_out == 0,
              "R1 reset outputs", {white_insert, loop_en, leak_strobe, meas_strobe, blank_out}, 7'b1000000);
        rst_n = 1'b1;
        @(negedge clk);
        check(white_insert == 1 && loop_en == 0, "R1 after release", {white_insert, loop_en}, 2'b10);

        // R4: retrace and lines ignored during warm-up
        frame_retrace = 1'b1;
        idle(2);
        pulse_line();
        check(leak_strobe == 0 && meas_strobe == 0, "R4 retrace in warm-up", {leak_strobe, meas_strobe}, 0);
        frame_retrace = 1'b0;
        pulse_line();
        pulse_line();
        check(meas_strobe == 0, "R4 lines in warm-up", meas_strobe, 0);

        // R2: beam detection ends warm-up
        @(negedge clk) beam_det = 1'b1;
        @(negedge clk) beam_det = 1'b0;
        check(loop_en == 1 && white_insert == 0, "R2 warm-up exit", {loop_en, white_insert}, 2'b10);
        idle(4);
        check(loop_en == 1 && white_insert == 0, "R3 beam loss ignored", {loop_en, white_insert}, 2'b10);

        // full frame
        frame_retrace = 1'b1;
        @(negedge clk);
        check(leak_strobe == 1, "R5 leak on retrace", leak_strobe, 1);
        pulse_line();
        check(leak_strobe == 1 && meas_strobe == 0, "R7 line in retrace", {leak_strobe, meas_strobe}, 4'b1000);
        frame_retrace = 1'b0;
        @(negedge clk);
        check(leak_strobe == 0 && meas_strobe == 0, "R5 leak ends", {leak_strobe, meas_strobe}, 0);
        idle(2);
        pulse_line();
        check(meas_strobe == 3'b001 && blank_out == 1, "R6 red line", meas_strobe, 1);
        idle(3);
        pulse_line();
        check(meas_strobe == 3'b010, "R6 green line", meas_strobe, 2);
        idle(3);
        pulse_line();
        check(meas_strobe == 3'b100, "R6 blue line", meas_strobe, 4);
        idle(3);
        pulse_line();
        check(meas_strobe == 0 && blank_out == 0, "R6 sequence end", {meas_strobe, blank_out}, 0);
        pulse_line();
        check(meas_strobe == 0, "R6 idle line", meas_strobe, 0);

        // R8: retrace in the middle of the green line
        frame_retrace = 1'b1;
        idle(3);
        frame_retrace = 1'b0;
        idle(2);
        pulse_line();
        pulse_line();
        check(meas_strobe == 3'b010, "R6 green before abort", meas_strobe, 2);
        frame_retrace = 1'b1;
        @(negedge clk);
        check(leak_strobe == 1 && meas_strobe == 0, "R8 abort", {leak_strobe, meas_strobe}, 4'b1000);
        idle(2);
        frame_retrace = 1'b0;

        // back-to-back line pulses
        idle(2);
        line_pulse = 1'b1;
        idle(2);
        check(meas_strobe == 3'b010, "R6 back-to-back", meas_strobe, 2);
        idle(2);
        line_pulse = 1'b0;
        @(negedge clk);
        check(meas_strobe == 0 && leak_strobe == 0, "R9 clean finish", {leak_strobe, meas_strobe}, 0);

        // R3: warm-up stays done across frames without beam
        frame_retrace = 1'b1;
        idle(2);
        frame_retrace = 1'b0;
        idle(2);
        pulse_line();
        check(loop_en == 1 && meas_strobe == 3'b001, "R3 still running", {loop_en, meas_strobe}, 4'b1001);
        idle(5);
        summary();
    end
endmodule